// File: doc/BRIEF.md
# Pulse-Verify Memory Programming Controller

This block is a sequencer that programs a 16-bit-wide one-time-programmable or UV-erasable memory. After a start command it steps through the array from the lowest address to the highest. At each address it presents the word taken from an address-indexed word source. It fires a programming pulse of fixed width, waits a settle delay, and reads the location back. While the read-back differs from the intended word it repeats the pulse, up to a limit. If the limit runs out, the sequence stops with a fail flag and the failing address.

While it programs, a supply-select output requests the raised core supply. Once the last address has been written, the block drops the select to the nominal level, waits one settle delay, and reads every address once more. A clean final pass gives a one-cycle done pulse. The first mismatch gives a fail flag with that address. Only select signals are produced here. Voltage generation and erasure belong to other logic.

Top module: `prog_verify_seq`

## Requirements
- R1: After reset, `pgm_pulse`, `verify_rd`, `supply_hi`, `busy`, `done` and `fail` are all 0 and `tgt_addr` is 0.
- R2: Each programming pulse holds `pgm_pulse` high for exactly PULSE_CLKS = CLK_MHZ*PULSE_US cycles. During the pulse `tgt_addr` does not change, and `prog_data` carries all 16 bits of the word presented on `word_in` for that address.
- R3: After every pulse, exactly SETTLE_CLKS cycles (at least 1) pass with neither strobe asserted. Then `verify_rd` is asserted for one cycle, and `rdback` is compared with `word_in` in that cycle.
- R4: A read-back that differs from the intended word causes another pulse at the same address. A match on the MAX_PULSES-th pulse still counts as success.
- R5: Addresses are programmed in ascending order from 0 to 2^AW-1. Each address receives exactly as many pulses as it takes to match, and never more than MAX_PULSES.
- R6: `supply_hi` is 1 throughout the pulse/verify phase, so every pulse sees it at 1. It is 0 during the final verify pass and while idle.
- R7: The final pass reads every address once, in ascending order, with `supply_hi` at 0. The first mismatch sets `fail`, loads `fail_addr` with that address, and ends the pass.
- R8: A mismatch after the MAX_PULSES-th pulse sets `fail` and loads `fail_addr`. Once `fail` rises, no further pulse is issued.
- R9: A clean final pass produces `done` high for exactly one cycle, never together with `fail`. `fail` stays set until the next `start`.
- R10: `pgm_pulse` and `verify_rd` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (sampled while idle) |
| word_in | input | DW | Intended word for the address on `tgt_addr` |
| rdback | input | DW | Word read back from the target memory |
| pgm_pulse | output | 1 | Programming pulse strobe |
| verify_rd | output | 1 | Verify-read strobe; `rdback` is compared in this cycle |
| supply_hi | output | 1 | 1 = raised programming supply, 0 = nominal level |
| tgt_addr | output | AW | Target address |
| prog_data | output | DW | Word driven to the target data pins |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse on a clean final pass |
| fail | output | 1 | Run ended in failure |
| fail_addr | output | AW | Address that caused the failure |

## Verification
Two decisions can fall in the same verify cycle: a read-back that finally matches, and the pulse budget running out. The bench sets up a target model in which one address needs exactly MAX_PULSES pulses, including the last address, where the match also triggers the switch to the nominal-supply pass. It judges the run by a done pulse with no fail and by exactly MAX_PULSES pulses counted at that address. A neighbouring run that needs one pulse more must instead end in fail at that address, with no pulses at later addresses.

// File: rtl/prog_verify_seq.sv
module prog_verify_seq #(
  parameter int AW          = 17,
  parameter int DW          = 16,
  parameter int CLK_MHZ     = 50,
  parameter int PULSE_US    = 100,
  parameter int SETTLE_CLKS = 4,
  parameter int MAX_PULSES  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] word_in,
  input  logic [DW-1:0] rdback,
  output logic          pgm_pulse,
  output logic          verify_rd,
  output logic          supply_hi,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] prog_data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int PULSE_CLKS = CLK_MHZ * PULSE_US;
  localparam int TW = $clog2(PULSE_CLKS + SETTLE_CLKS + 1);
  localparam int NW = $clog2(MAX_PULSES + 1);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_SETTLE, S_VREAD, S_FSETTLE, S_FREAD
  } state_t;

  state_t        state;
  logic [TW-1:0] tmr;
  logic [NW-1:0] npulse;
  logic [AW-1:0] addr;
  logic          match;

  assign match     = (rdback == word_in);
  assign pgm_pulse = (state == S_PULSE);
  assign verify_rd = (state == S_VREAD) || (state == S_FREAD);
  assign supply_hi = (state == S_PULSE) || (state == S_SETTLE) || (state == S_VREAD);
  assign busy      = (state != S_IDLE);
  assign tgt_addr  = addr;
  assign prog_data = word_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tmr       <= '0;
      npulse    <= '0;
      addr      <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          addr   <= '0;
          npulse <= '0;
          tmr    <= '0;
          fail   <= 1'b0;
          state  <= S_PULSE;
        end
        S_PULSE: if (tmr == TW'(PULSE_CLKS - 1)) begin
          tmr    <= '0;
          npulse <= npulse + 1'b1;
          state  <= S_SETTLE;
        end else tmr <= tmr + 1'b1;
        S_SETTLE: if (tmr == TW'(SETTLE_CLKS - 1)) begin
          tmr   <= '0;
          state <= S_VREAD;
        end else tmr <= tmr + 1'b1;
        S_VREAD: if (match) begin
          npulse <= '0;
          if (addr == LAST) begin
            addr  <= '0;
            state <= S_FSETTLE;
          end else begin
            addr  <= addr + 1'b1;
            state <= S_PULSE;
          end
        end else if (npulse == NW'(MAX_PULSES)) begin
          fail      <= 1'b1;
          fail_addr <= addr;
          state     <= S_IDLE;
        end else state <= S_PULSE;
        S_FSETTLE: if (tmr == TW'(SETTLE_CLKS - 1)) begin
          tmr   <= '0;
          state <= S_FREAD;
        end else tmr <= tmr + 1'b1;
        S_FREAD: if (!match) begin
          fail      <= 1'b1;
          fail_addr <= addr;
          state     <= S_IDLE;
        end else if (addr == LAST) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else addr <= addr + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prog_verify_seq_chk.sv
module prog_verify_seq_chk #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pgm_pulse,
  input logic          verify_rd,
  input logic          supply_hi,
  input logic [AW-1:0] tgt_addr,
  input logic [DW-1:0] prog_data,
  input logic          busy,
  input logic          done,
  input logic          fail
);
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_pulse && verify_rd));
  a_r6_pulse_raised: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |-> supply_hi);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_not_fail: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fail);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_pulse && $past(pgm_pulse)) |-> $stable(tgt_addr));
  a_r8_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (!busy && !pgm_pulse));
  a_r6_idle_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !supply_hi);
endmodule

bind prog_verify_seq prog_verify_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_prog_verify_seq.sv
`timescale 1ns/1ps
module test_prog_verify_seq;
  localparam int AW = 3, DW = 16, PCLK = 3, SET = 2, MAXP = 4, N = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DW-1:0] word_in, rdback, prog_data;
  logic pgm_pulse, verify_rd, supply_hi, busy, done, fail;
  logic [AW-1:0] tgt_addr, fail_addr;

  int checks = 0, failures = 0, cycles = 0;
  int need[N];
  int pulses[N];
  int bad_final = -1;
  int width_bad, gap_bad, data_bad, order_bad, supply_bad, freads, done_cnt, run_len, gap, last_paddr;
  logic prev_p, in_gap;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] wfn(input int a);
    return DW'(a * 16'h1111) ^ 16'h5A0F;
  endfunction

  assign word_in = wfn(int'(tgt_addr));
  always_comb begin
    if (pulses[tgt_addr] >= need[tgt_addr]) rdback = wfn(int'(tgt_addr));
    else rdback = '1;
    if (!supply_hi && verify_rd && int'(tgt_addr) == bad_final) rdback = rdback ^ 16'h0001;
  end

  prog_verify_seq #(.AW(AW), .DW(DW), .CLK_MHZ(1), .PULSE_US(PCLK),
                    .SETTLE_CLKS(SET), .MAX_PULSES(MAXP)) i_prog_verify_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (done) done_cnt++;
    if (pgm_pulse && !prev_p) begin
      pulses[tgt_addr]++;
      run_len = 0;
      if (int'(tgt_addr) < last_paddr) order_bad++;
      last_paddr = int'(tgt_addr);
    end
    if (pgm_pulse) begin
      run_len++;
      if (!supply_hi) supply_bad++;
      if (prog_data != wfn(int'(tgt_addr))) data_bad++;
    end
    if (!pgm_pulse && prev_p) begin
      if (run_len != PCLK) width_bad++;
      in_gap = 1; gap = 0;
    end
    if (in_gap && !pgm_pulse && !verify_rd) gap++;
    if (verify_rd && supply_hi) begin
      if (gap != SET) gap_bad++;
      in_gap = 0;
    end
    if (verify_rd && !supply_hi) begin
      if (int'(tgt_addr) != freads) order_bad++;
      freads++;
    end
    prev_p = pgm_pulse;
  end

  task automatic run(input string tag);
    int k = -1, t = 0;
    for (int i = 0; i < N; i++) pulses[i] = 0;
    width_bad = 0; gap_bad = 0; data_bad = 0; order_bad = 0; supply_bad = 0;
    freads = 0; done_cnt = 0; in_gap = 0; last_paddr = 0; prev_p = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    for (int i = 0; i < N; i++) if (k < 0 && need[i] > MAXP) k = i;
    for (int i = 0; i < N; i++) begin
      int e = (k < 0 || i < k) ? need[i] : (i == k ? MAXP : 0);
      chk({tag, " R4 R5 pulses per address"}, pulses[i], e);
    end
    chk({tag, " R2 pulse width"}, width_bad, 0);
    chk({tag, " R2 data applied"}, data_bad, 0);
    chk({tag, " R3 settle gap"}, gap_bad, 0);
    chk({tag, " R6 supply raised"}, supply_bad, 0);
    chk({tag, " R5 R7 address order"}, order_bad, 0);
    if (k >= 0) begin
      chk({tag, " R8 fail"}, int'(fail), 1);
      chk({tag, " R8 fail_addr"}, int'(fail_addr), k);
      chk({tag, " R7 no final reads"}, freads, 0);
      chk({tag, " R9 no done"}, done_cnt, 0);
    end else if (bad_final >= 0) begin
      chk({tag, " R7 fail"}, int'(fail), 1);
      chk({tag, " R7 fail_addr"}, int'(fail_addr), bad_final);
      chk({tag, " R7 final reads"}, freads, bad_final + 1);
      chk({tag, " R9 no done"}, done_cnt, 0);
    end else begin
      chk({tag, " R9 done once"}, done_cnt, 1);
      chk({tag, " R9 fail low"}, int'(fail), 0);
      chk({tag, " R7 final reads"}, freads, N);
    end
    chk({tag, " R6 idle nominal"}, int'(supply_hi), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    chk("R1 pulse", int'(pgm_pulse), 0);
    chk("R1 verify", int'(verify_rd), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done/fail", int'(done) + int'(fail), 0);
    chk("R1 supply", int'(supply_hi), 0);
    chk("R1 addr", int'(tgt_addr), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R10 idle strobes", int'(pgm_pulse) + int'(verify_rd), 0);
    run("single");
    for (int i = 0; i < N; i++) need[i] = (i % MAXP) + 1;
    run("ramp");
    for (int i = 0; i < N; i++) need[i] = MAXP;
    run("all_at_limit");
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) need[i] = 2;
      need[k] = MAXP + 1;
      run("over_limit");
    end
    for (int i = 0; i < N; i++) need[i] = 1;
    need[N-1] = MAXP;
    run("last_at_limit");
    for (int b = 0; b < N; b += 3) begin
      bad_final = b;
      run("final_mismatch");
    end
    bad_final = -1;
    run("R9 fail cleared by restart");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule